// File: doc/BRIEF.md
# Store Return State Execution Unit

This unit executes the privileged instruction that pushes the current link register and the current saved status register onto the banked stack of a chosen processor mode. It takes one 32-bit instruction word per issue, along with a flag that selects between the fixed 32-bit instruction set and the mixed 16/32-bit set. The issuing stage also supplies the outcome of the condition check, the current mode, exception level and security context, and the banked stack pointer of the target mode. The target mode is presented on `sp_rmode_o` so that the register file can return that pointer.

A legal instruction produces two word writes on a valid/ready memory port, in a fixed order. It then optionally writes an updated pointer back to the target mode's banked stack pointer. An illegal instruction produces no memory traffic and reports undefined, unpredictable or monitor-trap instead. Every accepted issue ends with a one-cycle `done_o`.

Top module: `srs_exec_unit`

## Requirements
- R1: A fixed-width word is recognised when [31:25]=1111100, [22]=1, [20]=0, [19:16]=1101 and [15:5]=00000101000, with P=[24], U=[23], W=[21] and target mode=[4:0]. Incrementing is U. The word-higher adjustment applies when P equals U. With base B, the first store address is B-4 for P=0,U=0; B-8 for P=1,U=0; B for P=0,U=1; and B+4 for P=1,U=1.
- R2: In the mixed set, the upper halfword is [31:16] and the lower halfword is [15:0]. A word with upper halfword 1110100000W01101 and lower halfword 11000000000 followed by the mode stores from B-8. A word with upper halfword 1110100110W01101 and the same lower layout stores from B. W is bit 5 of the upper halfword.
- R3: The first write carries the link register value to the start address. The second write carries the saved status value to the start address plus 4. The link register, saved status and base values are those sampled in the issue cycle.
- R4: With W=1, a single stack-pointer write follows both stores. It targets the target mode with value B+8 when incrementing and B-8 otherwise. With W=0, no stack-pointer write occurs.
- R5: At exception level 2 (`cur_el_i`=2), the instruction reports undefined and performs no writes.
- R6: Mode numbers are User 0x10, FIQ 0x11, IRQ 0x12, Supervisor 0x13, Monitor 0x16, Abort 0x17, Hyp 0x1A, Undefined 0x1B and System 0x1F. Any other value is invalid. The instruction reports unpredictable and performs no writes in any of these cases: the current mode is User or System; the target is Hyp; the target is invalid; or the target is Monitor while EL3 is absent or the state is non-secure.
- R7: A Monitor target with EL3 present, the Secure state and a 64-bit EL3 raises `mon_trap_o` with no writes. The same target with a 32-bit EL3 stores normally.
- R8: When `cond_pass_i` is low, the instruction completes with `done_o` only: no writes and no fault flag.
- R9: A store stays on the port with unchanged address and data until `mem_ready_i` is high.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last store or the pointer writeback. A fault flag is high only together with `done_o`, and at most one fault flag is high. `busy_o` is high from the cycle after issue until `done_o`.
- R11: A word that matches neither set's pattern reports undefined with no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Issue strobe, taken when not busy |
| t32_i | input | 1 | 1: mixed 16/32-bit set, 0: fixed 32-bit set |
| instr_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Condition check passed |
| cur_mode_i | input | 5 | Current processor mode number |
| cur_el_i | input | 2 | Current exception level |
| secure_i | input | 1 | Secure state |
| el3_present_i | input | 1 | EL3 implemented |
| el3_aarch64_i | input | 1 | EL3 uses the 64-bit architecture |
| lr_i | input | 32 | Current link register |
| spsr_i | input | 32 | Current saved status register |
| sp_base_i | input | 32 | Banked SP of the target mode |
| sp_rmode_o | output | 5 | Target mode decoded from instr_i, for the SP read |
| busy_o | output | 1 | Instruction in progress |
| mem_valid_o | output | 1 | Store request |
| mem_ready_i | input | 1 | Store accepted |
| mem_addr_o | output | 32 | Store address |
| mem_wdata_o | output | 32 | Store data |
| sp_we_o | output | 1 | Banked SP write enable |
| sp_wmode_o | output | 5 | Mode whose SP is written |
| sp_wdata_o | output | 32 | New SP value |
| done_o | output | 1 | Completion pulse |
| undef_o | output | 1 | Undefined instruction, valid with done_o |
| unpred_o | output | 1 | Unpredictable case, valid with done_o |
| mon_trap_o | output | 1 | Monitor-mode trap, valid with done_o |

## Verification
The assertions check the port contract on every cycle. They cover the stability of a stalled store, the +4 step from the first to the second store address, a pointer write only right after an accepted second store, the single-cycle completion pulse, and fault flags that are mutually exclusive and never occur without completion. They also check that an issue judged illegal or condition-failed never raises a store request. Only the bench scenarios can show the values themselves. These are the start address of each addressing variant in both sets, the writeback arithmetic, which legality rule wins for each mode and security combination, and the sampling of the link register and status value at issue.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_MON = 5'h16;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_HYP = 5'h1A;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  localparam logic [1:0] EL_HYP = 2'd2;

  typedef struct packed {
    logic       match;
    logic       increment;
    logic       wordhigher;
    logic       wback;
    logic [4:0] tgt_mode;
  } srs_dec_t;

  typedef enum logic [2:0] {
    V_STORE,
    V_SKIP,
    V_UNDEF,
    V_UNPRED,
    V_TRAP
  } srs_verdict_e;

  function automatic logic mode_is_valid(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_MON,
      MODE_ABT, MODE_HYP, MODE_UND, MODE_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/srs_decode.sv
module srs_decode
  import srs_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        t32_i,
  output srs_dec_t    dec_o
);
  localparam logic [6:0]  A_TOP   = 7'b1111100;
  localparam logic [10:0] A_MID   = 11'b00000101000;
  localparam logic [9:0]  T_DB_HI = 10'b1110100000;
  localparam logic [9:0]  T_IA_HI = 10'b1110100110;
  localparam logic [10:0] T_LO    = 11'b11000000000;

  logic [15:0] hw_hi, hw_lo;
  logic        a_hit, t_db_hit, t_ia_hit, t_lo_ok, t_base_ok;

  assign hw_hi = instr_i[31:16];
  assign hw_lo = instr_i[15:0];

  assign a_hit = (instr_i[31:25] == A_TOP) && instr_i[22] && !instr_i[20]
              && (instr_i[19:16] == 4'hD) && (instr_i[15:5] == A_MID);

  assign t_lo_ok   = (hw_lo[15:5] == T_LO);
  assign t_base_ok = (hw_hi[4:0] == 5'b01101) && t_lo_ok;
  assign t_db_hit  = (hw_hi[15:6] == T_DB_HI) && t_base_ok;
  assign t_ia_hit  = (hw_hi[15:6] == T_IA_HI) && t_base_ok;

  always_comb begin
    dec_o          = '0;
    dec_o.tgt_mode = instr_i[4:0];
    if (!t32_i) begin
      dec_o.match      = a_hit;
      dec_o.increment  = instr_i[23];
      dec_o.wordhigher = (instr_i[24] == instr_i[23]);
      dec_o.wback      = instr_i[21];
    end else begin
      dec_o.match      = t_db_hit || t_ia_hit;
      dec_o.increment  = t_ia_hit;
      dec_o.wordhigher = 1'b0;
      dec_o.wback      = hw_hi[5];
    end
  end
endmodule

// File: rtl/srs_check.sv
module srs_check
  import srs_pkg::*;
(
  input  srs_dec_t     dec_i,
  input  logic         cond_pass_i,
  input  logic [4:0]   cur_mode_i,
  input  logic [1:0]   cur_el_i,
  input  logic         secure_i,
  input  logic         el3_present_i,
  input  logic         el3_aarch64_i,
  output srs_verdict_e verdict_o
);
  logic cur_unpriv;
  assign cur_unpriv = (cur_mode_i == MODE_USR) || (cur_mode_i == MODE_SYS);

  // priority order matters: undefined wins over every unpredictable case
  always_comb begin
    if (!cond_pass_i)                     verdict_o = V_SKIP;
    else if (!dec_i.match)                verdict_o = V_UNDEF;
    else if (cur_el_i == EL_HYP)          verdict_o = V_UNDEF;
    else if (cur_unpriv)                  verdict_o = V_UNPRED;
    else if (dec_i.tgt_mode == MODE_HYP)  verdict_o = V_UNPRED;
    else if (dec_i.tgt_mode == MODE_MON) begin
      if (!el3_present_i || !secure_i)    verdict_o = V_UNPRED;
      else if (el3_aarch64_i)             verdict_o = V_TRAP;
      else                                verdict_o = V_STORE;
    end
    else if (!mode_is_valid(dec_i.tgt_mode)) verdict_o = V_UNPRED;
    else                                  verdict_o = V_STORE;
  end
endmodule

// File: rtl/srs_addr.sv
module srs_addr
  import srs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0] base_i,
  input  srs_dec_t      dec_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] new_sp_o
);
  localparam logic [AW-1:0] WORD_B = AW'(WORD_BYTES);
  localparam logic [AW-1:0] PAIR_B = AW'(2 * WORD_BYTES);

  logic [AW-1:0] low;
  assign low      = dec_i.increment ? base_i : base_i - PAIR_B;
  assign start_o  = dec_i.wordhigher ? low + WORD_B : low;
  assign new_sp_o = dec_i.increment ? base_i + PAIR_B : base_i - PAIR_B;
endmodule

// File: rtl/srs_exec_unit.sv
module srs_exec_unit
  import srs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          t32_i,
  input  logic [31:0]   instr_i,
  input  logic          cond_pass_i,
  input  logic [4:0]    cur_mode_i,
  input  logic [1:0]    cur_el_i,
  input  logic          secure_i,
  input  logic          el3_present_i,
  input  logic          el3_aarch64_i,
  input  logic [DW-1:0] lr_i,
  input  logic [DW-1:0] spsr_i,
  input  logic [AW-1:0] sp_base_i,
  output logic [4:0]    sp_rmode_o,
  output logic          busy_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          sp_we_o,
  output logic [4:0]    sp_wmode_o,
  output logic [AW-1:0] sp_wdata_o,
  output logic          done_o,
  output logic          undef_o,
  output logic          unpred_o,
  output logic          mon_trap_o
);
  localparam logic [AW-1:0] WORD_B = AW'(WORD_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_WB, S_RESP} st_e;

  st_e           st_q;
  srs_dec_t      dec;
  srs_verdict_e  verdict;
  logic [AW-1:0] start_addr, new_sp;
  logic [AW-1:0] addr_q, new_sp_q;
  logic [DW-1:0] lr_q, spsr_q;
  logic [4:0]    mode_q;
  logic          wb_q, undef_q, unpred_q, trap_q;
  logic          accept;

  srs_decode u_decode (
    .instr_i (instr_i),
    .t32_i   (t32_i),
    .dec_o   (dec)
  );

  srs_check u_check (
    .dec_i         (dec),
    .cond_pass_i   (cond_pass_i),
    .cur_mode_i    (cur_mode_i),
    .cur_el_i      (cur_el_i),
    .secure_i      (secure_i),
    .el3_present_i (el3_present_i),
    .el3_aarch64_i (el3_aarch64_i),
    .verdict_o     (verdict)
  );

  srs_addr #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base_i   (sp_base_i),
    .dec_i    (dec),
    .start_o  (start_addr),
    .new_sp_o (new_sp)
  );

  assign accept     = start_i && (st_q == S_IDLE);
  assign sp_rmode_o = dec.tgt_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      addr_q   <= '0;
      new_sp_q <= '0;
      lr_q     <= '0;
      spsr_q   <= '0;
      mode_q   <= '0;
      wb_q     <= 1'b0;
      undef_q  <= 1'b0;
      unpred_q <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          addr_q   <= start_addr;
          new_sp_q <= new_sp;
          lr_q     <= lr_i;
          spsr_q   <= spsr_i;
          mode_q   <= dec.tgt_mode;
          wb_q     <= dec.wback;
          undef_q  <= (verdict == V_UNDEF);
          unpred_q <= (verdict == V_UNPRED);
          trap_q   <= (verdict == V_TRAP);
          st_q     <= (verdict == V_STORE) ? S_LO : S_RESP;
        end
        S_LO:   if (mem_ready_i) st_q <= S_HI;
        S_HI:   if (mem_ready_i) st_q <= wb_q ? S_WB : S_RESP;
        S_WB:   st_q <= S_RESP;
        S_RESP: begin
          st_q     <= S_IDLE;
          undef_q  <= 1'b0;
          unpred_q <= 1'b0;
          trap_q   <= 1'b0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign mem_valid_o = (st_q == S_LO) || (st_q == S_HI);
  assign mem_addr_o  = (st_q == S_HI) ? addr_q + WORD_B : addr_q;
  assign mem_wdata_o = (st_q == S_HI) ? spsr_q : lr_q;
  assign sp_we_o     = (st_q == S_WB);
  assign sp_wmode_o  = mode_q;
  assign sp_wdata_o  = new_sp_q;
  assign done_o      = (st_q == S_RESP);
  assign undef_o     = done_o && undef_q;
  assign unpred_o    = done_o && unpred_q;
  assign mon_trap_o  = done_o && trap_q;

  // R9: a pending store holds its address and data
  a_r9_store_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R3: second store lands one word above the first
  a_r3_second_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LO) && mem_ready_i |=> mem_valid_o && (mem_addr_o == $past(mem_addr_o) + WORD_B));

  // R4: pointer write only right after an accepted store
  a_r4_wb_after_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> $past(mem_valid_o && mem_ready_i));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10: fault flags exclusive and only with completion
  a_r10_flags_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, unpred_o, mon_trap_o}) && ((undef_o || unpred_o || mon_trap_o) -> done_o));

  // R5 R6 R7 R8 R11: illegal or skipped issue never requests a store
  a_r8_no_store_when_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (verdict != V_STORE) |=> !mem_valid_o && done_o);
endmodule

// File: tb/srs_exec_unit_tb.sv
module srs_exec_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [31:0] LRV   = 32'hCAFE_0001;
  localparam logic [31:0] SPSRV = 32'h6000_01D3;
  localparam logic [31:0] BASE  = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, t32_i = 1'b0, cond_pass_i = 1'b1;
  logic [31:0] instr_i = '0;
  logic [4:0]  cur_mode_i = 5'h13;
  logic [1:0]  cur_el_i = 2'd1;
  logic secure_i = 1'b1, el3_present_i = 1'b1, el3_aarch64_i = 1'b0;
  logic [31:0] lr_i = '0, spsr_i = '0, sp_base_i = '0;
  logic mem_ready_i = 1'b0;
  logic [4:0]  sp_rmode_o, sp_wmode_o;
  logic busy_o, mem_valid_o, sp_we_o, done_o, undef_o, unpred_o, mon_trap_o;
  logic [31:0] mem_addr_o, mem_wdata_o, sp_wdata_o;

  int tests = 0, fails = 0, cyc = 0;
  int n_wr, n_sp, n_done, stalls;
  logic [31:0] wa0, wd0, wa1, wd1, sp_d;
  logic [4:0]  sp_m;
  logic f_und, f_unp, f_trap, pulse_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  srs_exec_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .t32_i(t32_i), .instr_i(instr_i),
    .cond_pass_i(cond_pass_i), .cur_mode_i(cur_mode_i), .cur_el_i(cur_el_i),
    .secure_i(secure_i), .el3_present_i(el3_present_i), .el3_aarch64_i(el3_aarch64_i),
    .lr_i(lr_i), .spsr_i(spsr_i), .sp_base_i(sp_base_i), .sp_rmode_o(sp_rmode_o),
    .busy_o(busy_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .sp_we_o(sp_we_o),
    .sp_wmode_o(sp_wmode_o), .sp_wdata_o(sp_wdata_o), .done_o(done_o),
    .undef_o(undef_o), .unpred_o(unpred_o), .mon_trap_o(mon_trap_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<%0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_a(input logic p, input logic u, input logic w, input logic [4:0] m);
    return {7'b1111100, p, u, 1'b1, w, 1'b0, 4'hD, 11'b00000101000, m};
  endfunction

  function automatic logic [31:0] enc_t(input logic ia, input logic w, input logic [4:0] m);
    return {(ia ? 10'b1110100110 : 10'b1110100000), w, 1'b0, 4'hD, 11'b11000000000, m};
  endfunction

  task automatic run_op(input logic [31:0] ins, input logic t32, input logic cond,
                        input logic [4:0] cmode, input logic [1:0] el, input logic sec,
                        input logic p3, input logic a64, input int stall);
    n_wr = 0; n_sp = 0; n_done = 0; stalls = 0;
    wa0 = '0; wd0 = '0; wa1 = '0; wd1 = '0; sp_d = '0; sp_m = '0;
    f_und = 0; f_unp = 0; f_trap = 0; pulse_ok = 0;
    @(negedge clk);
    instr_i = ins; t32_i = t32; cond_pass_i = cond; cur_mode_i = cmode; cur_el_i = el;
    secure_i = sec; el3_present_i = p3; el3_aarch64_i = a64;
    lr_i = LRV; spsr_i = SPSRV; sp_base_i = BASE; start_i = 1'b1; mem_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; lr_i = 32'hDEAD_0000; spsr_i = 32'hDEAD_1111; sp_base_i = 32'hDEAD_2222;
    for (int i = 0; i < 60; i++) begin
      mem_ready_i = (i >= stall);
      #1;
      if (mem_valid_o && !mem_ready_i) stalls++;
      if (mem_valid_o && mem_ready_i) begin
        if (n_wr == 0) begin wa0 = mem_addr_o; wd0 = mem_wdata_o; end
        else begin wa1 = mem_addr_o; wd1 = mem_wdata_o; end
        n_wr++;
      end
      if (sp_we_o) begin n_sp++; sp_d = sp_wdata_o; sp_m = sp_wmode_o; end
      if (done_o) begin
        n_done++; f_und = undef_o; f_unp = unpred_o; f_trap = mon_trap_o;
        @(negedge clk);
        pulse_ok = !done_o && !busy_o;
        break;
      end
      @(negedge clk);
    end
    mem_ready_i = 1'b0;
  endtask

  task automatic exp_store(input string tag, input logic [31:0] a0, input logic wb,
                           input logic [31:0] nsp, input logic [4:0] m);
    chk(n_done == 1 && pulse_ok, {tag, " R10 done pulse"}, n_done, 1);
    chk(n_wr == 2, {tag, " R3 store count"}, n_wr, 2);
    chk(wa0 == a0, {tag, " R1 first addr"}, wa0, a0);
    chk(wd0 == LRV && wa1 == a0 + 4 && wd1 == SPSRV, {tag, " R3 order/data"}, wd1, SPSRV);
    chk(n_sp == (wb ? 1 : 0), {tag, " R4 sp write count"}, n_sp, wb);
    if (wb) chk(sp_d == nsp && sp_m == m, {tag, " R4 sp value"}, sp_d, nsp);
    chk({f_und, f_unp, f_trap} == 3'b000, {tag, " R10 no flags"}, {f_und, f_unp, f_trap}, 0);
  endtask

  task automatic exp_fault(input string tag, input logic [2:0] fl);
    chk(n_done == 1 && pulse_ok, {tag, " done pulse"}, n_done, 1);
    chk(n_wr == 0 && n_sp == 0, {tag, " no writes"}, n_wr + n_sp, 0);
    chk({f_und, f_unp, f_trap} == fl, {tag, " flags"}, {f_und, f_unp, f_trap}, fl);
  endtask

  task automatic t_reset;
    #1;
    chk(!busy_o && !mem_valid_o && !done_o && !sp_we_o, "R10 reset idle", {busy_o, mem_valid_o, done_o, sp_we_o}, 0);
  endtask

  task automatic t_fixed_variants;
    run_op(enc_a(0, 0, 1, 5'h13), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R1 DA", BASE - 4, 1, BASE - 8, 5'h13);
    run_op(enc_a(1, 0, 1, 5'h12), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R1 DB", BASE - 8, 1, BASE - 8, 5'h12);
    run_op(enc_a(0, 1, 1, 5'h11), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R1 IA", BASE, 1, BASE + 8, 5'h11);
    run_op(enc_a(1, 1, 0, 5'h17), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R1 IB noW R4", BASE + 4, 0, 0, 5'h17);
  endtask

  task automatic t_mixed;
    run_op(enc_t(0, 1, 5'h1B), 1, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R2 T-DB", BASE - 8, 1, BASE - 8, 5'h1B);
    run_op(enc_t(1, 1, 5'h13), 1, 1, 5'h11, 1, 1, 1, 0, 0); exp_store("R2 T-IA", BASE, 1, BASE + 8, 5'h13);
    run_op(enc_t(1, 0, 5'h12), 1, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R2 T-IA noW", BASE, 0, 0, 5'h12);
  endtask

  task automatic t_stall;
    run_op(enc_a(1, 1, 1, 5'h13), 0, 1, 5'h13, 1, 1, 1, 0, 4);
    chk(stalls == 4, "R9 stall cycles seen", stalls, 4);
    exp_store("R9 stalled", BASE + 4, 1, BASE + 8, 5'h13);
  endtask

  task automatic t_undef;
    run_op(enc_a(0, 1, 1, 5'h13), 0, 1, 5'h13, 2'd2, 1, 1, 0, 0); exp_fault("R5 EL2", 3'b100);
    run_op(enc_a(0, 1, 1, 5'h13) ^ 32'h0000_0100, 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_fault("R11 bad fixed", 3'b100);
    run_op(enc_t(0, 1, 5'h13) ^ 32'h0001_0000, 1, 1, 5'h13, 1, 1, 1, 0, 0); exp_fault("R11 bad mixed", 3'b100);
  endtask

  task automatic t_unpred;
    run_op(enc_a(0, 1, 1, 5'h13), 0, 1, 5'h10, 1, 1, 1, 0, 0); exp_fault("R6 cur User", 3'b010);
    run_op(enc_a(0, 1, 1, 5'h13), 0, 1, 5'h1F, 1, 1, 1, 0, 0); exp_fault("R6 cur System", 3'b010);
    run_op(enc_a(0, 1, 1, 5'h1A), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_fault("R6 tgt Hyp", 3'b010);
    run_op(enc_a(0, 1, 1, 5'h15), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_fault("R6 tgt invalid", 3'b010);
    run_op(enc_a(0, 1, 1, 5'h16), 0, 1, 5'h13, 1, 0, 1, 0, 0); exp_fault("R6 mon nonsecure", 3'b010);
    run_op(enc_a(0, 1, 1, 5'h16), 0, 1, 5'h13, 1, 1, 0, 0, 0); exp_fault("R6 mon no EL3", 3'b010);
  endtask

  task automatic t_monitor;
    run_op(enc_a(0, 1, 1, 5'h16), 0, 1, 5'h13, 1, 1, 1, 1, 0); exp_fault("R7 mon trap", 3'b001);
    run_op(enc_a(0, 1, 1, 5'h16), 0, 1, 5'h13, 1, 1, 1, 0, 0); exp_store("R7 mon store", BASE, 1, BASE + 8, 5'h16);
  endtask

  task automatic t_cond;
    run_op(enc_a(0, 1, 1, 5'h1A), 0, 0, 5'h10, 2'd2, 1, 1, 0, 0); exp_fault("R8 cond fail", 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    t_reset();
    t_fixed_variants();
    t_mixed();
    t_stall();
    t_undef();
    t_unpred();
    t_monitor();
    t_cond();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule